// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter meant to serve as the operating-system tick in a small processor core. Software programs a period through a reload register and starts the counter from a control register. At the end of every period the block sets a sticky count flag and, if software asked for it, raises a one-cycle interrupt request toward the interrupt controller. Each count step comes either from the core clock or from a single-cycle reference-tick enable input, and a control bit selects which.

Software reaches four word registers over a simple request/response port. Every request receives a registered response one cycle later. Requests marked as unprivileged are refused with an error response and leave all state untouched. Undefined or misaligned offsets read as zero and ignore writes, with an OK response. The counter width, the address width and the calibration constant are parameters.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control bits, the count flag, the reload value, the counter and `irq` are all zero, so the control, reload and current registers all read 0.
- R2: The control register sits at byte offset 0x0. Its bit 0 is enable, bit 1 is interrupt enable, bit 2 is source select (1 = core clock, 0 = `ref_tick`) and bit 16 is the count flag. All other bits read 0. A write changes only bits 2:0.
- R3: Once enabled, one period lasts reload+1 count steps. A count step is every clock cycle when source select is 1, and every cycle with `ref_tick` high when it is 0.
- R4: At the end of each period the count flag is set. `irq` is high for exactly one cycle, in the cycle after the period ends, and only if interrupt enable is 1.
- R5: A read of the control register returns the count flag as it stood and then clears it.
- R6: A write of any value to the current register (offset 0x8) clears the count flag. If enable is 1 it also reloads the counter from the reload register (offset 0x4, low CNT_W bits stored).
- R7: If the reload value is 0 when a period ends, enable is cleared and counting stops.
- R8: While enable is 0, the current register reads 0 and the counter holds its value. Setting enable resumes from the held value if that value is nonzero, and loads the reload value otherwise.
- R9: Changing source select while enable stays 1 reloads the counter from the reload register.
- R10: The calibration register at offset 0xC reads the constant CAL_VALUE (10000 by default).
- R11: A request with `req_user` high gets `rsp_err` = 1 and `rsp_rdata` = 0 and changes no register.
- R12: A privileged access to an offset other than 0x0, 0x4, 0x8 or 0xC reads 0, is ignored on write, and gets `rsp_err` = 0.
- R13: Every request is answered by `rsp_valid` high for one cycle, in the cycle after the request. Without a request, `rsp_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Single-cycle reference count enable |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Unprivileged access marker |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Error response for unprivileged access |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench builds the timer with an 8-bit counter and an 8-bit address. With that width it can sweep every nonzero reload value from 1 to 255 in core-clock mode and compare each measured interval between interrupts with reload+1. A reference tick every third cycle checks period scaling in reference mode, and a hand-driven single reference pulse shows that the count moves only on enabled steps. The small width also keeps the write-truncation and wrap-to-zero corners within a few hundred cycles.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned BIT_EN   = 0;
   localparam int unsigned BIT_INT  = 1;
   localparam int unsigned BIT_SRC  = 2;
   localparam int unsigned BIT_FLAG = 16;

   typedef enum logic [2:0] {
      SEL_CTRL,
      SEL_RELOAD,
      SEL_CUR,
      SEL_CAL,
      SEL_NONE
   } reg_sel_e;

   typedef struct packed {
      logic wr_ctrl;
      logic wr_reload;
      logic wr_cur;
      logic rd_ctrl;
   } strobe_t;

endpackage

// File: rtl/tick_timer_bus.sv
module tick_timer_bus
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned CAL_VALUE = 10000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic                 req_user,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    ctrl_word,
   input  logic [CNT_W-1:0]     reload_val,
   input  logic [CNT_W-1:0]     cur_val,
   output strobe_t              stb,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [DATA_W-1:0]    rsp_rdata
);

   localparam int unsigned PAD_W = DATA_W - CNT_W;

   logic                hi_clear;
   reg_sel_e            sel;
   logic                access_ok;
   logic [DATA_W-1:0]   reload_ext;
   logic [DATA_W-1:0]   cur_ext;
   logic [DATA_W-1:0]   rd_mux;

   // upper address bits must be zero for a defined offset
   generate
      if (ADDR_W > 4) begin : g_hi_addr
         assign hi_clear = ~|req_addr[ADDR_W-1:4];
      end else begin : g_no_hi_addr
         assign hi_clear = 1'b1;
      end
   endgenerate

   // zero extension of counter-width values to the bus width
   generate
      if (PAD_W > 0) begin : g_pad
         assign reload_ext = {{PAD_W{1'b0}}, reload_val};
         assign cur_ext    = {{PAD_W{1'b0}}, cur_val};
      end else begin : g_nopad
         assign reload_ext = reload_val;
         assign cur_ext    = cur_val;
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (hi_clear && (req_addr[1:0] == 2'b00)) begin
         case (req_addr[3:2])
            2'd0:    sel = SEL_CTRL;
            2'd1:    sel = SEL_RELOAD;
            2'd2:    sel = SEL_CUR;
            default: sel = SEL_CAL;
         endcase
      end
   end

   assign access_ok = req_valid && !req_user;

   always_comb begin
      stb.wr_ctrl   = access_ok &&  req_write && (sel == SEL_CTRL);
      stb.wr_reload = access_ok &&  req_write && (sel == SEL_RELOAD);
      stb.wr_cur    = access_ok &&  req_write && (sel == SEL_CUR);
      stb.rd_ctrl   = access_ok && !req_write && (sel == SEL_CTRL);
   end

   always_comb begin
      case (sel)
         SEL_CTRL:   rd_mux = ctrl_word;
         SEL_RELOAD: rd_mux = reload_ext;
         SEL_CUR:    rd_mux = cur_ext;
         SEL_CAL:    rd_mux = DATA_W'(CAL_VALUE);
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && req_user;
         rsp_rdata <= (access_ok && !req_write) ? rd_mux : '0;
      end
   end

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  strobe_t          stb,
   input  logic [CNT_W-1:0] wdata,
   input  logic             wrap,
   output logic             en_q,
   output logic             tint_q,
   output logic             src_q,
   output logic             flag_q,
   output logic [CNT_W-1:0] reload_q,
   output logic             op_start,
   output logic             op_reload,
   output logic             op_zero,
   output logic             irq
);

   logic en_n;
   logic reload_zero;

   assign reload_zero = (reload_q == '0);

   // counter commands derived from the access in this cycle
   assign op_start  = stb.wr_ctrl && !en_q && wdata[BIT_EN];
   assign op_reload = (stb.wr_cur && en_q) ||
                      (stb.wr_ctrl && en_q && wdata[BIT_EN] &&
                       (wdata[BIT_SRC] != src_q));
   assign op_zero   = stb.wr_cur && !en_q;

   always_comb begin
      en_n = en_q;
      if (stb.wr_ctrl) begin
         en_n = wdata[BIT_EN];
      end
      if (wrap && reload_zero) begin
         en_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         tint_q   <= 1'b0;
         src_q    <= 1'b0;
         flag_q   <= 1'b0;
         reload_q <= '0;
         irq      <= 1'b0;
      end else begin
         en_q <= en_n;
         if (stb.wr_ctrl) begin
            tint_q <= wdata[BIT_INT];
            src_q  <= wdata[BIT_SRC];
         end
         if (stb.wr_reload) begin
            reload_q <= wdata;
         end
         if (wrap) begin
            flag_q <= 1'b1;
         end else if (stb.rd_ctrl || stb.wr_cur) begin
            flag_q <= 1'b0;
         end
         irq <= wrap && tint_q;
      end
   end

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_q,
   input  logic             src_core,
   input  logic             ref_tick,
   input  logic             op_start,
   input  logic             op_reload,
   input  logic             op_zero,
   input  logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);

   logic step;
   logic busy_op;
   logic at_zero;

   assign step    = src_core ? 1'b1 : ref_tick;
   assign busy_op = op_start || op_reload || op_zero;
   assign at_zero = (cnt_q == '0);
   assign wrap    = en_q && step && !busy_op && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (op_zero) begin
         cnt_q <= '0;
      end else if (op_reload) begin
         cnt_q <= reload_q;
      end else if (op_start) begin
         if (at_zero) begin
            cnt_q <= reload_q;
         end
      end else if (en_q && step) begin
         if (at_zero) begin
            cnt_q <= reload_q;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned CAL_VALUE = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              irq
);

   generate
      if (CNT_W < 3 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("tick_timer: CNT_W must lie in 3..32");
      end
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("tick_timer: ADDR_W must be at least 4");
      end
   endgenerate

   strobe_t             stb;
   logic                en_q;
   logic                tint_q;
   logic                src_q;
   logic                flag_q;
   logic [CNT_W-1:0]    reload_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [CNT_W-1:0]    cur_val;
   logic                op_start;
   logic                op_reload;
   logic                op_zero;
   logic                wrap;
   logic [DATA_W-1:0]   ctrl_word;

   generate
      if (CNT_W < DATA_W) begin : g_wdata_hi
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^req_wdata[DATA_W-1:CNT_W];
      end
   endgenerate

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[BIT_EN]   = en_q;
      ctrl_word[BIT_INT]  = tint_q;
      ctrl_word[BIT_SRC]  = src_q;
      ctrl_word[BIT_FLAG] = flag_q;
   end

   assign cur_val = en_q ? cnt_q : '0;

   tick_timer_bus #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .CAL_VALUE (CAL_VALUE)
   ) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_user   (req_user),
      .req_addr   (req_addr),
      .ctrl_word  (ctrl_word),
      .reload_val (reload_q),
      .cur_val    (cur_val),
      .stb        (stb),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata)
   );

   tick_timer_ctrl #(
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (stb),
      .wdata     (req_wdata[CNT_W-1:0]),
      .wrap      (wrap),
      .en_q      (en_q),
      .tint_q    (tint_q),
      .src_q     (src_q),
      .flag_q    (flag_q),
      .reload_q  (reload_q),
      .op_start  (op_start),
      .op_reload (op_reload),
      .op_zero   (op_zero),
      .irq       (irq)
   );

   tick_timer_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_q      (en_q),
      .src_core  (src_q),
      .ref_tick  (ref_tick),
      .op_start  (op_start),
      .op_reload (op_reload),
      .op_zero   (op_zero),
      .reload_q  (reload_q),
      .cnt_q     (cnt_q),
      .wrap      (wrap)
   );

endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
   parameter int unsigned CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic             req_user,
   input logic             rsp_valid,
   input logic             rsp_err,
   input logic [31:0]      rsp_rdata,
   input logic             irq,
   input logic             en_q,
   input logic             flag_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] reload_q,
   input logic             wrap
);

   assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag_q);

   assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag_q);

   assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && (reload_q == '0)) |=> !en_q);

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !(req_valid && req_write && !req_user)) |=> $stable(cnt_q));

   assert_user_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user) |=> (rsp_valid && rsp_err && (rsp_rdata == 32'd0)));

   assert_user_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user) |=> $stable(reload_q));

   assert_priv_ok_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_user) |=> (rsp_valid && !rsp_err));

   assert_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_user  (req_user),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .irq       (irq),
   .en_q      (en_q),
   .flag_q    (flag_q),
   .cnt_q     (cnt_q),
   .reload_q  (reload_q),
   .wrap      (wrap)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;

   localparam int unsigned ADDR_W = 8;
   localparam int unsigned CNT_W  = 8;
   localparam int unsigned WD_MAX = 150000;

   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_RLD  = 8'h04;
   localparam logic [7:0] A_CUR  = 8'h08;
   localparam logic [7:0] A_CAL  = 8'h0C;
   localparam logic [31:0] FLAG  = 32'h0001_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_auto = 1'b0;
   logic              ref_auto_tick = 1'b0;
   logic              ref_man = 1'b0;
   logic              ref_tick;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic              req_user = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid;
   logic              rsp_err;
   logic [31:0]       rsp_rdata;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int irq_cnt = 0;
   int irq_last = 0;
   int irq_prev = 0;
   int ref_phase = 0;
   logic [31:0] rd;
   logic        er;

   assign ref_tick = ref_auto_tick | ref_man;

   always #2.5 clk = ~clk;

   tick_timer #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_user  (req_user),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata),
      .irq       (irq)
   );

   // cycle count, interrupt log, reference tick every third cycle, watchdog
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (irq) begin
         irq_cnt  = irq_cnt + 1;
         irq_prev = irq_last;
         irq_last = cyc;
      end
      if (ref_auto) begin
         ref_phase = (ref_phase == 2) ? 0 : ref_phase + 1;
         ref_auto_tick = (ref_phase == 0);
      end else begin
         ref_auto_tick = 1'b0;
      end
      if (cyc > WD_MAX) begin
         n_chk  = n_chk + 1;
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_MAX);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit usr);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      req_user  = usr;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
      req_user  = 1'b0;
      rd = rsp_rdata;
      er = rsp_err;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus(1'b1, a, d, 1'b0);
   endtask

   task automatic rd_reg(input logic [7:0] a);
      bus(1'b0, a, 32'd0, 1'b0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_irqs(input int target);
      int n;
      n = 0;
      while (irq_cnt < target && n < 5000) begin
         @(negedge clk);
         n = n + 1;
      end
   endtask

   task automatic measure(input int rl, input logic [31:0] ctl, input int exp_len, input string tag);
      int base;
      wr_reg(A_CTRL, 32'd0);
      wr_reg(A_CUR, 32'd0);
      wr_reg(A_RLD, rl);
      base = irq_cnt;
      wr_reg(A_CTRL, ctl);
      wait_irqs(base + 2);
      check(tag, irq_last - irq_prev, exp_len);
   endtask

   initial begin
      int ic0;
      logic [31:0] v;

      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      check("R1 irq", {31'd0, irq}, 32'd0);
      rd_reg(A_CTRL); check("R1 ctrl", rd, 32'd0);
      rd_reg(A_RLD);  check("R1 reload", rd, 32'd0);
      rd_reg(A_CUR);  check("R1 current", rd, 32'd0);

      // R10: calibration constant
      rd_reg(A_CAL);  check("R10 calibration", rd, 32'd10000);

      // R2: only bits 2:0 writable; R13 response strobe
      wr_reg(A_CTRL, 32'hFFFF_FFF8);
      rd_reg(A_CTRL); check("R2 upper bits ignored", rd, 32'd0);
      wr_reg(A_CTRL, 32'h0000_0006);
      rd_reg(A_CTRL); check("R2 int and source bits", rd, 32'h6);
      wr_reg(A_CTRL, 32'd0);
      wr_reg(A_RLD, 32'hFFFF_FF55);
      rd_reg(A_RLD);  check("R6 reload keeps low CNT_W bits", rd, 32'h55);
      @(negedge clk); check("R13 idle no response", {31'd0, rsp_valid}, 32'd0);

      // R11: unprivileged accesses
      bus(1'b1, A_RLD, 32'h33, 1'b1);
      check("R11 user write error", {31'd0, er}, 32'd1);
      rd_reg(A_RLD);  check("R11 reload unchanged", rd, 32'h55);
      bus(1'b0, A_CAL, 32'd0, 1'b1);
      check("R11 user read error", {31'd0, er}, 32'd1);
      check("R11 user read data zero", rd, 32'd0);
      bus(1'b1, A_CTRL, 32'h7, 1'b1);
      rd_reg(A_CTRL); check("R11 user ctrl write ignored", rd, 32'd0);

      // R12: undefined offsets
      rd_reg(8'h10);  check("R12 undefined read data", rd, 32'd0);
      check("R12 undefined read ok", {31'd0, er}, 32'd0);
      wr_reg(8'h14, 32'h7);
      check("R12 undefined write ok", {31'd0, er}, 32'd0);
      rd_reg(A_CTRL); check("R12 ctrl untouched", rd, 32'd0);
      rd_reg(8'h06);  check("R12 misaligned read", rd, 32'd0);
      rd_reg(A_RLD);  check("R12 reload untouched", rd, 32'h55);

      // R7: reload zero stops after one period
      wr_reg(A_CUR, 32'd0);
      wr_reg(A_RLD, 32'd0);
      ic0 = irq_cnt;
      wr_reg(A_CTRL, 32'h7);
      idle(6);
      check("R7 single interrupt", irq_cnt - ic0, 32'd1);
      rd_reg(A_CTRL); check("R7 enable cleared, flag set", rd, FLAG | 32'h6);
      rd_reg(A_CTRL); check("R5 flag cleared by read", rd, 32'h6);
      rd_reg(A_CUR);  check("R7 current reads zero", rd, 32'd0);

      // R3 R4: full sweep of reload values on the core clock
      for (int r = 1; r < 256; r++) begin
         measure(r, 32'h7, r + 1, "R3 core period");
      end
      wr_reg(A_CTRL, 32'd0);

      // R4 R5: flag without interrupt enable
      wr_reg(A_CUR, 32'd0);
      wr_reg(A_RLD, 32'd200);
      ic0 = irq_cnt;
      wr_reg(A_CTRL, 32'h5);
      idle(210);
      rd_reg(A_CTRL); check("R5 flag reads set", rd, FLAG | 32'h5);
      rd_reg(A_CTRL); check("R5 flag cleared after read", rd, 32'h5);
      check("R4 no irq with interrupt disabled", irq_cnt - ic0, 32'd0);

      // R6: current write reloads and clears flag
      idle(210);
      wr_reg(A_CUR, 32'hDEAD_BEEF);
      rd_reg(A_CUR);  check("R6 counter reloaded", rd, 32'd199);
      rd_reg(A_CTRL); check("R6 flag cleared", rd, 32'h5);

      // R8: freeze and resume
      wr_reg(A_CTRL, 32'h4);
      rd_reg(A_CUR);  check("R8 disabled reads zero", rd, 32'd0);
      idle(20);
      wr_reg(A_CTRL, 32'h5);
      rd_reg(A_CUR);
      v = rd;
      check("R8 resumed from held value", {31'd0, (v > 32'd185 && v < 32'd200)}, 32'd1);

      // R9: source change reloads; R3 reference gating
      idle(20);
      wr_reg(A_CTRL, 32'h1);
      rd_reg(A_CUR);  check("R9 reload on source change", rd, 32'd200);
      rd_reg(A_CUR);  check("R3 no ref tick, no count", rd, 32'd200);
      @(negedge clk); ref_man = 1'b1;
      @(negedge clk); ref_man = 1'b0;
      rd_reg(A_CUR);  check("R3 one ref tick, one count", rd, 32'd199);

      // R3: reference tick every third cycle
      ref_auto = 1'b1;
      measure(4, 32'h3, 15, "R3 ref period reload 4");
      measure(9, 32'h3, 30, "R3 ref period reload 9");

      // R11: user write cannot stop a running timer
      bus(1'b1, A_CTRL, 32'd0, 1'b1);
      rd_reg(A_CTRL); check("R11 running timer untouched", rd & 32'h7, 32'h3);
      wr_reg(A_CTRL, 32'd0);
      ref_auto = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule